// File: doc/BRIEF.md
# Dual-Source Reset Conditioner

This block turns two unrelated, active-high reset requests into one internal reset for a design that runs on a single clock. Each request has its own chain of plain flip-flops clocked by the system clock, which brings it into the clock domain. The two chain outputs are merged by an OR. The merged value is then captured in one last flip-flop. The Q of that flip-flop is the only reset that downstream logic sees.

Downstream registers take this output on their asynchronous reset ports. Because of that, the output is never driven by logic after the final flip-flop. None of the flip-flops here has a reset, preset or enable. They all start at 0 from their initial value, so the output stays low after power-up until a request has moved through the block.

Top module: `rst_cond_dual`

## Requirements
- R1: Each of the two request inputs passes through its own chain of SYNC_DEPTH flip-flops. SYNC_DEPTH defaults to 2, and any value below 2 is rejected at elaboration.
- R2: A request that is sampled high at rising clock edge k forces `rst_o` high right after edge k+SYNC_DEPTH. The output is therefore high within SYNC_DEPTH+1 edges of the request.
- R3: Either request on its own is enough to produce the reset: the output is the OR of the two synchronized requests, registered once more.
- R4: Once both requests are sampled low from edge k onward, `rst_o` goes low right after edge k+SYNC_DEPTH and then stays low.
- R5: After power-up, `rst_o` reads 0 and stays 0 until a request sampled at a clock edge has reached the end of the pipeline.
- R6: A request pulse that rises and falls between two rising edges has no effect on `rst_o`. A request that is high at exactly one edge gives a `rst_o` pulse exactly one cycle long.
- R7: `rst_o` changes only at rising clock edges and holds its value for the rest of each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| req_a_i | input | 1 | First raw reset request, active high, any timing |
| req_b_i | input | 1 | Second raw reset request, active high, any timing |
| rst_o | output | 1 | Registered internal reset, active high |

## Verification
A stage that is missing, doubled or stuck in one chain shows up at `rst_o` as a reset edge that comes one or more cycles early or late. This appears within SYNC_DEPTH+1 cycles of the first request on that input. A wrong merge shows up the first time only one request is active: the output either stays low or fails to release. A flip-flop that starts at 1, or logic placed after the last flip-flop, shows up as `rst_o` being high in the first cycles after power-up, or changing in the middle of a cycle. The reference model is compared against the output twice in every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   // Smallest chain that still gives a metastable first stage a full cycle to settle
   localparam int unsigned RSTC_MIN_DEPTH = 2;

   // Edges from a sampled request to the visible output
   function automatic int unsigned rstc_latency(input int unsigned depth);
      return depth + 1;
   endfunction
endpackage

// File: rtl/rstc_sync_chain.sv
module rstc_sync_chain
   import rstc_pkg::*;
#(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk_i,
   input  logic req_i,
   output logic sync_o
);
   localparam int unsigned LAST = DEPTH - 1;

   // Each stage is a plain D flip-flop with only D, clock and Q, starting at 0
   logic [DEPTH-1:0] stage = '0;

   generate
      if (DEPTH < RSTC_MIN_DEPTH) begin : g_bad_depth
         $error("rstc_sync_chain: DEPTH must be at least %0d", RSTC_MIN_DEPTH);
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk_i) stage[0] <= req_i;
         end else begin : g_next
            always_ff @(posedge clk_i) stage[g] <= stage[g-1];
         end
      end
   endgenerate

   assign sync_o = stage[LAST];

   // Checker state: how many edges in a row the request has been sampled high or low
   int unsigned run_hi = 0;
   int unsigned run_lo = 0;
   always_ff @(posedge clk_i) begin
      if (req_i) begin
         run_hi <= (run_hi < DEPTH) ? run_hi + 1 : run_hi;
         run_lo <= 0;
      end else begin
         run_lo <= (run_lo < DEPTH) ? run_lo + 1 : run_lo;
         run_hi <= 0;
      end
   end

   // R1: a request held for DEPTH edges must have reached the chain output
   p_chain_high_r1: assert property (@(posedge clk_i) disable iff (run_hi < DEPTH)
      sync_o);
   // R1: a quiet input held for DEPTH edges must have cleared the chain output
   p_chain_low_r1: assert property (@(posedge clk_i) disable iff (run_lo < DEPTH)
      !sync_o);
endmodule

// File: rtl/rstc_out_flop.sv
module rstc_out_flop (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   // The last register: its Q goes straight out, with no logic after it
   logic q = 1'b0;
   always_ff @(posedge clk_i) q <= d_i;
   assign q_o = q;
endmodule

// File: rtl/rst_cond_dual.sv
module rst_cond_dual
   import rstc_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk_i,
   input  logic req_a_i,
   input  logic req_b_i,
   output logic rst_o
);
   localparam int unsigned LAT = rstc_latency(SYNC_DEPTH);

   logic sync_a;
   logic sync_b;
   logic merged;

   generate
      if (SYNC_DEPTH < RSTC_MIN_DEPTH) begin : g_bad_depth
         $error("rst_cond_dual: SYNC_DEPTH must be at least %0d", RSTC_MIN_DEPTH);
      end
   endgenerate

   rstc_sync_chain #(.DEPTH(SYNC_DEPTH)) i_chain_a (
      .clk_i (clk_i),
      .req_i (req_a_i),
      .sync_o(sync_a)
   );

   rstc_sync_chain #(.DEPTH(SYNC_DEPTH)) i_chain_b (
      .clk_i (clk_i),
      .req_i (req_b_i),
      .sync_o(sync_b)
   );

   assign merged = sync_a | sync_b;

   rstc_out_flop i_out (
      .clk_i(clk_i),
      .d_i  (merged),
      .q_o  (rst_o)
   );

   // Checker state: power-up marker, plus run lengths of the merged raw request
   logic        warm   = 1'b0;
   int unsigned any_hi = 0;
   int unsigned any_lo = 0;
   always_ff @(posedge clk_i) begin
      warm <= 1'b1;
      if (req_a_i || req_b_i) begin
         any_hi <= (any_hi < LAT) ? any_hi + 1 : any_hi;
         any_lo <= 0;
      end else begin
         any_lo <= (any_lo < LAT) ? any_lo + 1 : any_lo;
         any_hi <= 0;
      end
   end

   // R3: the output is one edge behind the OR of the two synchronized requests
   p_merge_r3: assert property (@(posedge clk_i) disable iff (!warm)
      rst_o == $past(sync_a || sync_b));
   // R2: a request on either input held for SYNC_DEPTH+1 edges has asserted the output
   p_assert_lat_r2: assert property (@(posedge clk_i) disable iff (any_hi < LAT)
      rst_o);
   // R4: both inputs quiet for SYNC_DEPTH+1 edges has released the output
   p_release_lat_r4: assert property (@(posedge clk_i) disable iff (any_lo < LAT)
      !rst_o);
endmodule

// File: tb/test_rst_cond_dual.sv
module test_rst_cond_dual;
   localparam int unsigned DEPTH = 2;
   localparam int unsigned LAT   = DEPTH + 1;

   logic clk = 1'b0;
   logic req_a = 1'b0;
   logic req_b = 1'b0;
   logic rst_o;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   string       phase = "R5";
   bit          done  = 1'b0;

   always #10 clk = ~clk;

   rst_cond_dual #(.SYNC_DEPTH(DEPTH)) i_rst_cond_dual (
      .clk_i  (clk),
      .req_a_i(req_a),
      .req_b_i(req_b),
      .rst_o  (rst_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: rst_o=%b expected %b", req, $time, act, exp);
      end
   endtask

   // Reference model: the OR of both requests seen at each edge, delayed by LAT edges
   bit   hist[$];
   logic expect_q = 1'b0;
   always @(posedge clk) begin
      hist.push_back(req_a | req_b);
      if (hist.size() > LAT) void'(hist.pop_front());
      expect_q = (hist.size() == LAT) ? hist[0] : 1'b0;
      #5;
      if (!done) check(phase, rst_o, expect_q);
      #10;
      if (!done) check("R7", rst_o, expect_q);   // R7: still steady late in the cycle
   end

   task automatic to_neg();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) to_neg();
   endtask

   // Raise the chosen request and count the edges until the output goes high
   task automatic measure_rise(input bit use_b, input string req);
      int edges = 0;
      to_neg();
      if (use_b) req_b = 1'b1; else req_a = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1;
         edges++;
         if (rst_o) break;
      end
      n_cmp++;
      if (edges != LAT) begin
         n_bad++;
         $display("FAIL %s: rise after %0d edges expected %0d", req, edges, LAT);
      end
   endtask

   task automatic measure_fall(input string req);
      int edges = 0;
      to_neg();
      req_a = 1'b0; req_b = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1;
         edges++;
         if (!rst_o) break;
      end
      n_cmp++;
      if (edges != LAT) begin
         n_bad++;
         $display("FAIL %s: fall after %0d edges expected %0d", req, edges, LAT);
      end
   endtask

   initial begin
      #1 check("R5", rst_o, 1'b0);           // R5: output is low at power-up
      phase = "R5"; idle(6);
      phase = "R2"; measure_rise(1'b0, "R2"); idle(4);
      phase = "R4"; measure_fall("R4"); idle(4);
      phase = "R3"; measure_rise(1'b1, "R3"); idle(3);
      phase = "R4"; measure_fall("R4"); idle(4);
      // R3: overlapping requests keep the reset high until both have gone
      phase = "R3";
      req_a = 1'b1; idle(3); req_b = 1'b1; idle(2); req_a = 1'b0; idle(4);
      req_b = 1'b0; idle(6);
      // R6: a pulse that lies wholly between two edges is ignored
      phase = "R6";
      for (int k = 0; k < 3; k++) begin
         to_neg(); #2 req_a = 1'b1; #3 req_a = 1'b0;
         #1 req_b = 1'b1; #2 req_b = 1'b0;
      end
      idle(6);
      // R6: a request high at one edge only gives a one-cycle pulse
      to_neg(); req_b = 1'b1; to_neg(); req_b = 1'b0; idle(6);
      // R1: the two inputs alternate at random, each through its own chain
      phase = "R1";
      for (int k = 0; k < 300; k++) begin
         to_neg();
         req_a = ($urandom_range(0, 3) == 0);
         req_b = ($urandom_range(0, 4) == 0);
      end
      req_a = 1'b0; req_b = 1'b0; idle(8);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule